// File: doc/BRIEF.md
# Shared Two-Client Vector Execution Arbiter

This block is one vector execution unit that serves two integer-core clients. The datapath is 256 bits wide and is built from two 128-bit halves. Each client has its own request port. On that port the client asks for a narrow operation, which uses the low 128 bits of its operands, or a wide operation, which uses all 256 bits. Each cycle a scheduler looks at both clients and hands out the halves. A client that is alone gets the full width. When both clients ask, each is guaranteed one half.

A wide operation therefore finishes in one pass when the other client is silent. It needs two passes, lower half first, when the other client also wants the unit. The partial lower result is held inside the block between the two passes. Operands travel with the request, because the unit reads no memory. The arithmetic is modelled as a lane-wise add or exclusive-or. Each client has a private response slot. A result appears there, with a per-client sequence number, one cycle after its request is accepted.

Top module: `simd_share_top`

## Requirements
- R1: After reset all response valids are low, and each client's first response carries sequence number 0.
- R2: When both clients present narrow operations in the same cycle, both are accepted in that cycle.
- R3: A wide operation presented while the other client has no request is accepted in the cycle it is first presented.
- R4: A wide operation presented in the same cycle as a request from the other client is accepted one cycle later, after the lower half has been computed.
- R5: A request held valid is accepted no later than the cycle after it is first presented, whatever the other client does.
- R6: Op code 0 adds and op code 1 exclusive-ors, independently in each 128-bit half with no carry between halves. A narrow result returns the low 128 bits of the operands' result and zero in bits 255:128.
- R7: Response slot c is valid exactly one cycle after an accept on client c's port. It carries only client c's results.
- R8: Each client's sequence number increments by one per response and wraps modulo 2^SEQ_W (16 by default).
- R9: A wide operation split over two passes returns the lower half from its first pass joined with the upper half from its second pass. This holds even if the other client has gone idle in between.
- R10: When both clients present wide operations together, both are split and both are accepted in the second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 2 | Per-client request valid; bit c belongs to client c, held until accepted |
| req_wide | input | 2 | Per-client width select: 1 = 256-bit operation, 0 = 128-bit |
| req_op | input | 2 | Per-client op code: 0 = add, 1 = exclusive-or |
| req_a | input | 512 | Operand A; bits [256c+255:256c] belong to client c |
| req_b | input | 512 | Operand B, same layout as req_a |
| req_ready | output | 2 | Per-client accept; handshake when valid and ready are both high at a clock edge |
| rsp_valid | output | 2 | Per-client response valid |
| rsp_data | output | 512 | Per-client result, same layout as req_a |
| rsp_seq | output | 8 | Per-client sequence number; bits [4c+3:4c] belong to client c |

## Verification
Two things can happen in the same cycle and interfere with each other. One is splitting a wide operation because the other client contends. The other is finishing a two-pass operation while new requests arrive on the other port. The bench provokes this by launching both clients' drivers at the same clock edge with every mix of narrow and wide widths, random and carry-heavy operands, and back-to-back pairs. A scoreboard queue per client holds the expected result and sequence number. Each driver measures how many cycles its request waited and compares that with the wait the width mix implies.

// File: rtl/simd_share_pkg.sv
package simd_share_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_XOR = 1'b1
  } lane_op_e;

  localparam int NUM_CLI = 2;
  localparam int NUM_HALF = 2;
endpackage

// File: rtl/half_alu.sv
module half_alu
  import simd_share_pkg::*;
#(
  parameter int W = 128
) (
  input  lane_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    if (op == OP_XOR) y = a ^ b;
    else              y = a + b;
  end
endmodule

// File: rtl/share_sched.sv
module share_sched
  import simd_share_pkg::*;
(
  input  logic [NUM_CLI-1:0]      valid,
  input  logic [NUM_CLI-1:0]      wide,
  input  logic [NUM_CLI-1:0]      half_done,
  output logic [NUM_CLI-1:0][1:0] gnt,
  output logic [NUM_CLI-1:0]      ready
);
  logic [NUM_CLI-1:0][1:0] need;
  logic [2:0]              total;
  logic                    tight;

  always_comb begin
    for (int c = 0; c < NUM_CLI; c++) begin
      if (!valid[c])                     need[c] = 2'd0;
      else if (wide[c] && !half_done[c]) need[c] = 2'd2;
      else                               need[c] = 2'd1;
    end
    total = {1'b0, need[0]} + {1'b0, need[1]};
    tight = (total > 3'd2);
    for (int c = 0; c < NUM_CLI; c++) begin
      gnt[c]   = (tight && need[c] != 2'd0) ? 2'd1 : need[c];
      ready[c] = valid[c] && (gnt[c] == need[c]);
    end
  end
endmodule

// File: rtl/client_track.sv
module client_track #(
  parameter int W     = 128,
  parameter int SEQ_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic           done,
  input  logic           wide,
  input  logic [1:0]     gnt,
  input  logic [W-1:0]   lane_mine,
  input  logic [2*W-1:0] lane_pair,
  output logic           half_done,
  output logic           rsp_valid,
  output logic [2*W-1:0] rsp_data,
  output logic [SEQ_W-1:0] rsp_seq
);
  logic             hd_d, hd_q;
  logic [W-1:0]     lo_q;
  logic             lo_en;
  logic [2*W-1:0]   data_d;
  logic [SEQ_W-1:0] seq_q;

  always_comb begin
    lo_en = valid && (gnt == 2'd1) && wide && !hd_q;
    hd_d  = hd_q;
    if (lo_en) hd_d = 1'b1;
    if (done)  hd_d = 1'b0;
    if (gnt == 2'd2)  data_d = lane_pair;
    else if (wide)    data_d = {lane_mine, lo_q};
    else              data_d = {{W{1'b0}}, lane_mine};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q      <= 1'b0;
      lo_q      <= '0;
      seq_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_seq   <= '0;
    end else begin
      hd_q      <= hd_d;
      rsp_valid <= done;
      if (lo_en) lo_q <= lane_mine;
      if (done) begin
        rsp_data <= data_d;
        rsp_seq  <= seq_q;
        seq_q    <= seq_q + 1'b1;
      end
    end
  end

  assign half_done = hd_q;

  // R9: a half-finished wide operation keeps its request in place
  p_half_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |-> (valid && wide));
endmodule

// File: rtl/simd_share_top.sv
module simd_share_top
  import simd_share_pkg::*;
#(
  parameter int LANE_W = 128,
  parameter int SEQ_W  = 4,
  localparam int CW    = 2 * LANE_W,
  localparam int BUS_W = NUM_CLI * CW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CLI-1:0]         req_valid,
  input  logic [NUM_CLI-1:0]         req_wide,
  input  logic [NUM_CLI-1:0]         req_op,
  input  logic [BUS_W-1:0]           req_a,
  input  logic [BUS_W-1:0]           req_b,
  output logic [NUM_CLI-1:0]         req_ready,
  output logic [NUM_CLI-1:0]         rsp_valid,
  output logic [BUS_W-1:0]           rsp_data,
  output logic [NUM_CLI*SEQ_W-1:0]   rsp_seq
);
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [NUM_CLI-1:0][1:0]         gnt;
  logic [NUM_CLI-1:0]              half_done;
  logic [NUM_HALF-1:0]             src, part;
  logic [NUM_HALF-1:0][LANE_W-1:0] lane_a, lane_b, lane_y;
  lane_op_e [NUM_HALF-1:0]         lane_op;

  share_sched u_sched (
    .valid     (req_valid),
    .wide      (req_wide),
    .half_done (half_done),
    .gnt       (gnt),
    .ready     (req_ready)
  );

  always_comb begin
    for (int l = 0; l < NUM_HALF; l++) begin
      if (gnt[0] == 2'd2) begin
        src[l] = 1'b0; part[l] = l[0];
      end else if (gnt[1] == 2'd2) begin
        src[l] = 1'b1; part[l] = l[0];
      end else begin
        src[l] = l[0]; part[l] = req_wide[l] && half_done[l];
      end
    end
  end

  generate
    for (genvar l = 0; l < NUM_HALF; l++) begin : g_lane
      int idx;
      always_comb begin
        idx        = (int'(src[l]) * CW) + (int'(part[l]) * LANE_W);
        lane_a[l]  = req_a[idx +: LANE_W];
        lane_b[l]  = req_b[idx +: LANE_W];
        lane_op[l] = lane_op_e'(req_op[src[l]]);
      end
      half_alu #(.W(LANE_W)) u_alu (
        .op (lane_op[l]),
        .a  (lane_a[l]),
        .b  (lane_b[l]),
        .y  (lane_y[l])
      );
    end

    for (genvar c = 0; c < NUM_CLI; c++) begin : g_cli
      client_track #(.W(LANE_W), .SEQ_W(SEQ_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_s),
        .valid     (req_valid[c]),
        .done      (req_ready[c]),
        .wide      (req_wide[c]),
        .gnt       (gnt[c]),
        .lane_mine (lane_y[c]),
        .lane_pair ({lane_y[1], lane_y[0]}),
        .half_done (half_done[c]),
        .rsp_valid (rsp_valid[c]),
        .rsp_data  (rsp_data[c*CW +: CW]),
        .rsp_seq   (rsp_seq[c*SEQ_W +: SEQ_W])
      );

      // R7: a response follows exactly one accept on the same client
      p_rsp_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_s)
        rsp_valid[c] |-> $past(req_valid[c] && req_ready[c]));
      // R5: no request waits more than one cycle
      p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_s)
        (req_valid[c] && !req_ready[c]) |=> req_ready[c]);
      // R3: a lone wide request goes through in one pass
      p_wide_solo_r3: assert property (@(posedge clk) disable iff (!rst_s)
        (req_valid[c] && req_wide[c] && !req_valid[1-c] && !half_done[c])
          |-> req_ready[c]);
    end
  endgenerate

  // R2: two narrow requests share the datapath in the same cycle
  p_narrow_pair_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (&req_valid && !(|req_wide)) |-> (&req_ready));
endmodule

// File: tb/sim_simd_share_top.sv
module sim_simd_share_top;
  localparam int LW = 128;
  localparam int CW = 256;
  localparam int SW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     req_valid = '0, req_wide = '0, req_op = '0;
  logic [511:0]   req_a = '0, req_b = '0;
  logic [1:0]     req_ready, rsp_valid;
  logic [511:0]   rsp_data;
  logic [7:0]     rsp_seq;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] exp_q0[$], exp_q1[$];
  logic [SW-1:0] exp_seq [2];
  bit            running = 1'b0;

  always #5 clk = ~clk;

  simd_share_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wide(req_wide),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_seq(rsp_seq)
  );

  task automatic check(input bit ok, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] model(input bit wide, input bit op,
                                          input logic [CW-1:0] a,
                                          input logic [CW-1:0] b);
    logic [CW-1:0] r = '0;
    for (int h = 0; h < 2; h++) begin
      if (h == 0 || wide)
        r[h*LW +: LW] = op ? (a[h*LW +: LW] ^ b[h*LW +: LW])
                           : (a[h*LW +: LW] + b[h*LW +: LW]);
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] rnd();
    logic [CW-1:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic issue(input int c, input bit wide, input bit op,
                       input logic [CW-1:0] a, input logic [CW-1:0] b,
                       input int exp_wait, input string tag);
    int waited = 0;
    if (c == 0) exp_q0.push_back(model(wide, op, a, b));
    else        exp_q1.push_back(model(wide, op, a, b));
    @(negedge clk);
    req_wide[c] = wide; req_op[c] = op;
    req_a[c*CW +: CW] = a; req_b[c*CW +: CW] = b;
    req_valid[c] = 1'b1;
    #1;
    while (!req_ready[c] && waited < 5) begin
      @(negedge clk); #1; waited++;
    end
    check(waited == exp_wait && waited <= 1,
          $sformatf("%s R5 accept wait client %0d", tag, c), waited, exp_wait);
    @(posedge clk); #1;
    req_valid[c] = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < 2; c++) begin
        if (rsp_valid[c]) begin
          logic [CW-1:0] e;
          if ((c == 0 ? exp_q0.size() : exp_q1.size()) == 0) begin
            check(1'b0, $sformatf("R7 unexpected response client %0d", c), 1, 0);
          end else begin
            e = (c == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
            check(rsp_data[c*CW +: CW] === e,
                  $sformatf("R6 R9 result client %0d", c), rsp_data[c*CW +: CW], e);
            check(rsp_seq[c*SW +: SW] === exp_seq[c],
                  $sformatf("R8 R1 sequence client %0d", c),
                  rsp_seq[c*SW +: SW], exp_seq[c]);
            exp_seq[c] = exp_seq[c] + 1'b1;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_seq[0] = '0; exp_seq[1] = '0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 2'b00, "R1 response valid after reset", rsp_valid, 0);
    check(req_ready == 2'b00, "R1 ready idle after reset", req_ready, 0);
    running = 1'b1;

    // R3: wide alone on each client
    issue(0, 1'b1, 1'b0, rnd(), rnd(), 0, "R3 wide solo c0");
    issue(1, 1'b1, 1'b1, rnd(), rnd(), 0, "R3 wide solo c1");
    // R2: two narrow ops together
    fork
      issue(0, 1'b0, 1'b0, rnd(), rnd(), 0, "R2 narrow pair");
      issue(1, 1'b0, 1'b1, rnd(), rnd(), 0, "R2 narrow pair");
    join
    // R4 / R9: wide split against narrow, both orders
    fork
      issue(0, 1'b1, 1'b0, rnd(), rnd(), 1, "R4 wide split");
      issue(1, 1'b0, 1'b0, rnd(), rnd(), 0, "R4 narrow partner");
    join
    fork
      issue(0, 1'b0, 1'b1, rnd(), rnd(), 0, "R4 narrow partner");
      issue(1, 1'b1, 1'b0, rnd(), rnd(), 1, "R4 wide split");
    join
    // R10: both wide
    fork
      issue(0, 1'b1, 1'b0, rnd(), rnd(), 1, "R10 both wide");
      issue(1, 1'b1, 1'b1, rnd(), rnd(), 1, "R10 both wide");
    join
    // R6: carry must not cross halves, alone and split
    issue(0, 1'b1, 1'b0, {CW{1'b1}}, {{(CW-1){1'b0}}, 1'b1}, 0, "R6 carry solo");
    fork
      issue(0, 1'b1, 1'b0, {CW{1'b1}}, {CW{1'b1}}, 1, "R6 R9 carry split");
      issue(1, 1'b0, 1'b0, {CW{1'b1}}, {{(CW-1){1'b0}}, 1'b1}, 0, "R6 narrow carry");
    join
    // R8: sequence wraps past 16
    for (int i = 0; i < 20; i++) begin
      fork
        issue(0, 1'b0, i[0], rnd(), rnd(), 0, "R8 wrap");
        issue(1, 1'b0, i[1], rnd(), rnd(), 0, "R8 wrap");
      join
    end
    // random mix: wait equals own width when both present
    for (int i = 0; i < 40; i++) begin
      bit w0 = $urandom_range(0, 1);
      bit w1 = $urandom_range(0, 1);
      fork
        issue(0, w0, $urandom_range(0, 1), rnd(), rnd(), int'(w0), "R4 R10 mix");
        issue(1, w1, $urandom_range(0, 1), rnd(), rnd(), int'(w1), "R4 R10 mix");
      join
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R7 all responses returned",
          exp_q0.size() + exp_q1.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule